// File: doc/BRIEF.md
# Pack-Halfword Execute Unit

This unit decodes and executes a halfword pack operation from either of two 32-bit instruction formats: a fixed-width format and a compact format built from two halfwords. A direction bit in the word picks the variant. With the bit clear, the second operand is shifted left, and the result takes its upper half from that shifted value and its lower half from the first operand. With the bit set, the second operand is shifted right arithmetically, and the two halves trade places. The shift amount is an immediate taken from the instruction.

The caller reads the register file. It presents the instruction word, a format select and both operand values on an input stream. One cycle after the unit accepts a word, the output stream carries the packed value, the destination index, the condition field and two encoding flags. A word that is not recognised, or that is undefined, still produces an output beat, with the result forced to zero so that downstream logic can drop it. The shift path has no data-dependent iteration, so latency never depends on operand values.

Both sides use valid/ready. A beat moves when valid and ready are high in the same cycle. The input is ready whenever the output register is empty or is being drained in that cycle. While the output is stalled, every output field holds its value.

Top module: `pkh_exec`

## Requirements
- R1: With `in_compact`=0, a word is recognised only when bits 27:20 equal 8'b01101000 and bits 5:4 equal 2'b01. Its fields are: direction in bit 6, shift amount in bits 11:7, first source in 19:16, destination in 15:12, second source in 3:0. Any word that is not recognised sets `out_undef`.
- R2: With `in_compact`=0, a condition field (bits 31:28) of 4'b1111 makes the word unrecognised, so `out_undef` is 1.
- R3: With `in_compact`=1, a word is recognised only when bits 31:25 equal 7'b1110101 and bits 24:21 equal 4'b0110. Its fields are: direction in bit 5, shift amount in {bits 14:12, bits 7:6}, first source in 19:16, destination in 11:8, second source in 3:0.
- R4: With `in_compact`=1, bit 20 or bit 4 set to 1 sets `out_undef`.
- R5: `out_unpred` is 1 when the destination, first-source or second-source index equals 15.
- R6: With the direction bit at 0, the result is {(B << amount)[31:16], A[15:0]}. An amount of 0 leaves B unshifted.
- R7: With the direction bit at 1, the result is {A[31:16], (B >>> n)[15:0]}, an arithmetic right shift. n equals the amount, except that an amount of 0 gives n = 32, which fills every bit with B[31].
- R8: When `out_undef` is 1, `out_result` is zero and `out_valid` still asserts.
- R9: An accepted input beat produces `out_valid`=1 exactly one cycle later. Synchronous reset clears `out_valid` and leaves `in_ready`=1.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output field holds its value.
- R11: `out_cond` carries bits 31:28 for the fixed format and 4'b1110 for the compact format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_insn | input | 32 | Instruction word |
| in_compact | input | 1 | 0 = fixed-width format, 1 = compact format |
| in_op_a | input | 32 | First source operand value |
| in_op_b | input | 32 | Second source operand value (the one that is shifted) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_result | output | 32 | Packed result, zero when undefined |
| out_dest | output | 4 | Destination register index |
| out_cond | output | 4 | Condition field passed through |
| out_undef | output | 1 | Word unrecognised or undefined |
| out_unpred | output | 1 | A register index equals 15 |

## Verification
The bench builds the unit with the package defaults: a 32-bit datapath, a 5-bit shift field and 4-bit register indices. These values make every encodable shift amount reachable, including the encoded-zero case that means a full 32-bit arithmetic shift, and every register index including 15. Random words in both formats are mixed with single-bit corruptions so that recognition, undefined and unpredictable cases all occur. Directed stalls exercise back-pressure on the output register.

// File: rtl/pkh_pkg.sv
`timescale 1ns/1ps
package pkh_pkg;
  localparam int WORD_W  = 32;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = DATA_W / 2;
  localparam int IDX_W   = 4;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_RESERVED = '1;
  localparam logic [3:0] COND_ALWAYS = 4'b1110;

  typedef struct packed {
    logic               undef;
    logic               unpred;
    logic               dir;
    logic [SHAMT_W-1:0] shamt;
    logic [IDX_W-1:0]   dest;
    logic [3:0]         cond;
  } pkh_dec_t;
endpackage

// File: rtl/pkh_decode.sv
`timescale 1ns/1ps
module pkh_decode
  import pkh_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  input  logic              compact,
  output pkh_dec_t          dec
);
  logic             rec_fix, rec_cmp;
  logic [IDX_W-1:0] src_a, src_b;

  always_comb begin
    rec_fix = (insn[31:28] != 4'b1111) && (insn[27:20] == 8'b0110_1000) &&
              (insn[5:4] == 2'b01);
    rec_cmp = (insn[31:25] == 7'b1110101) && (insn[24:21] == 4'b0110);
    src_a   = insn[19:16];
    src_b   = insn[3:0];
    dec     = '0;
    if (compact) begin
      dec.undef = !rec_cmp || insn[20] || insn[4];
      dec.dir   = insn[5];
      dec.shamt = {insn[14:12], insn[7:6]};
      dec.dest  = insn[11:8];
      dec.cond  = COND_ALWAYS;
    end else begin
      dec.undef = !rec_fix;
      dec.dir   = insn[6];
      dec.shamt = insn[11:7];
      dec.dest  = insn[15:12];
      dec.cond  = insn[31:28];
    end
    dec.unpred = (dec.dest == IDX_RESERVED) || (src_a == IDX_RESERVED) ||
                 (src_b == IDX_RESERVED);
  end
endmodule

// File: rtl/pkh_shift.sv
`timescale 1ns/1ps
module pkh_shift #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic          arith,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  res
);
  logic [AW:0] eff;

  always_comb begin
    eff = (arith && (amt == '0)) ? (AW+1)'(W) : {1'b0, amt};
    if (arith) res = W'($signed(val) >>> eff);
    else       res = val << eff;
  end

  always_comb begin
    if (arith && (amt == '0))
      assert_asr_zero_is_full_R7: assert (res == {W{val[W-1]}});
    if (!arith && (amt == '0))
      assert_lsl_zero_passes_R6: assert (res == val);
  end
endmodule

// File: rtl/pkh_exec.sv
`timescale 1ns/1ps
module pkh_exec
  import pkh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_insn,
  input  logic              in_compact,
  input  logic [DATA_W-1:0] in_op_a,
  input  logic [DATA_W-1:0] in_op_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_dest,
  output logic [3:0]        out_cond,
  output logic              out_undef,
  output logic              out_unpred
);
  pkh_dec_t          dec;
  logic [DATA_W-1:0] shifted, packed_val;
  logic              accept;

  pkh_decode u_dec (.insn(in_insn), .compact(in_compact), .dec(dec));

  pkh_shift #(.W(DATA_W), .AW(SHAMT_W)) u_shift (
    .val(in_op_b), .arith(dec.dir), .amt(dec.shamt), .res(shifted)
  );

  always_comb begin
    if (dec.undef)    packed_val = '0;
    else if (dec.dir) packed_val = {in_op_a[DATA_W-1:HALF_W], shifted[HALF_W-1:0]};
    else              packed_val = {shifted[DATA_W-1:HALF_W], in_op_a[HALF_W-1:0]};
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_dest   <= '0;
      out_cond   <= '0;
      out_undef  <= 1'b0;
      out_unpred <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= packed_val;
        out_dest   <= dec.dest;
        out_cond   <= dec.cond;
        out_undef  <= dec.undef;
        out_unpred <= dec.unpred;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  assert_beat_next_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_dest) && $stable(out_undef) && $stable(out_unpred)));
  assert_undef_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_result == '0));
  assert_drain_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/pkh_exec_tb_top.sv
`timescale 1ns/1ps
module pkh_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_compact = 1'b0, out_ready = 1'b1;
  logic [31:0] in_insn = '0, in_op_a = '0, in_op_b = '0;
  logic        in_ready, out_valid, out_undef, out_unpred;
  logic [31:0] out_result;
  logic [3:0]  out_dest, out_cond;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pkh_exec dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_compact(in_compact), .in_op_a(in_op_a),
    .in_op_b(in_op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_dest(out_dest), .out_cond(out_cond),
    .out_undef(out_undef), .out_unpred(out_unpred)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] w, input logic cmp,
      input logic [31:0] a, input logic [31:0] b, output logic [31:0] r,
      output logic [3:0] d, output logic u, output logic p, output logic [3:0] c);
    logic       dir;
    logic [4:0] amt;
    logic [3:0] sa, sb;
    logic [31:0] sh;
    int n;
    sa = w[19:16]; sb = w[3:0];
    if (cmp) begin
      u = !(w[31:25] == 7'b1110101 && w[24:21] == 4'b0110) || w[20] || w[4];
      dir = w[5]; amt = {w[14:12], w[7:6]}; d = w[11:8]; c = 4'b1110;
    end else begin
      u = !(w[31:28] != 4'hF && w[27:20] == 8'h68 && w[5:4] == 2'b01);
      dir = w[6]; amt = w[11:7]; d = w[15:12]; c = w[31:28];
    end
    p = (d == 4'hF) || (sa == 4'hF) || (sb == 4'hF);
    sh = b;
    if (dir) begin
      n = (amt == 0) ? 32 : int'(amt);
      for (int i = 0; i < n; i++) sh = {sh[31], sh[31:1]};
      r = {a[31:16], sh[15:0]};
    end else begin
      for (int i = 0; i < int'(amt); i++) sh = {sh[30:0], 1'b0};
      r = {sh[31:16], a[15:0]};
    end
    if (u) r = '0;
  endfunction

  function automatic logic [31:0] mk_fix(logic [3:0] cond, logic [3:0] rn, logic [3:0] rd,
      logic [4:0] amt, logic dir, logic [3:0] rm);
    return {cond, 8'b0110_1000, rn, rd, amt, dir, 2'b01, rm};
  endfunction

  function automatic logic [31:0] mk_cmp(logic s, logic [3:0] rn, logic [4:0] amt,
      logic [3:0] rd, logic dir, logic t, logic [3:0] rm);
    return {7'b1110101, 4'b0110, s, rn, 1'b0, amt[4:2], rd, amt[1:0], dir, t, rm};
  endfunction

  task automatic send(input logic [31:0] w, input logic cmp, input logic [31:0] a,
      input logic [31:0] b, input string tag);
    logic [31:0] er; logic [3:0] ed, ec; logic eu, ep;
    model(w, cmp, a, b, er, ed, eu, ep, ec);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_compact = cmp; in_op_a = a; in_op_b = b;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, 32'(out_valid), 32'd1);
    chk({tag, " result"}, out_result, er);
    chk({tag, cmp ? " R3 dest" : " R1 dest"}, 32'(out_dest), 32'(ed));
    chk({tag, " undef R4"}, 32'(out_undef), 32'(eu));
    chk({tag, " R5 unpred"}, 32'(out_unpred), 32'(ep));
    chk({tag, " R11 cond"}, 32'(out_cond), 32'(ec));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, a, b, er, er2;
    logic [3:0] ed, ec; logic eu, ep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset valid", 32'(out_valid), 32'd0);
    chk("R9 reset ready", 32'(in_ready), 32'd1);

    send(mk_fix(4'h0, 4'd1, 4'd2, 5'd0, 1'b0, 4'd3), 1'b0, 32'hAAAA_1234, 32'h5678_9ABC, "R6 lsl0");
    send(mk_fix(4'h3, 4'd1, 4'd2, 5'd31, 1'b0, 4'd3), 1'b0, 32'h1111_2222, 32'h0000_0001, "R6 lsl31");
    send(mk_fix(4'hE, 4'd1, 4'd2, 5'd0, 1'b1, 4'd3), 1'b0, 32'hCAFE_0000, 32'h8000_0000, "R7 asr32 neg");
    send(mk_fix(4'hE, 4'd1, 4'd2, 5'd0, 1'b1, 4'd3), 1'b0, 32'hCAFE_0000, 32'h7FFF_FFFF, "R7 asr32 pos");
    send(mk_fix(4'h1, 4'd1, 4'd2, 5'd1, 1'b1, 4'd3), 1'b0, 32'h1234_5678, 32'hF000_0003, "R7 asr1");
    send(mk_fix(4'hF, 4'd1, 4'd2, 5'd4, 1'b0, 4'd3), 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R8 cond15");
    send(mk_fix(4'h0, 4'd1, 4'd2, 5'd4, 1'b0, 4'd3) ^ 32'h0000_0020, 1'b0, 32'hFFFF_FFFF, 32'h1, "R1 R8 badop");
    send(mk_cmp(1'b1, 4'd1, 5'd3, 4'd2, 1'b0, 1'b0, 4'd3), 1'b1, 32'hFFFF_FFFF, 32'h1, "R4 sbit");
    send(mk_cmp(1'b0, 4'd1, 5'd3, 4'd2, 1'b0, 1'b1, 4'd3), 1'b1, 32'hFFFF_FFFF, 32'h1, "R4 tbit");
    send(mk_cmp(1'b0, 4'd5, 5'd0, 4'd6, 1'b1, 1'b0, 4'd7), 1'b1, 32'h1357_9BDF, 32'h8765_4321, "R3 R7 cmp asr32");
    send(mk_cmp(1'b0, 4'd15, 5'd8, 4'd6, 1'b0, 1'b0, 4'd7), 1'b1, 32'h1, 32'h00FF_00FF, "R5 R6 cmp src15");
    send(mk_fix(4'h2, 4'd0, 4'd15, 5'd2, 1'b0, 4'd0), 1'b0, 32'h1, 32'h3, "R5 dest15");

    // R10 back-pressure: stall first beat, present second
    w = mk_fix(4'h4, 4'd1, 4'd2, 5'd8, 1'b0, 4'd3);
    a = 32'h0BAD_F00D; b = 32'h0000_1234;
    model(w, 1'b0, a, b, er, ed, eu, ep, ec);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_compact = 1'b0; in_op_a = a; in_op_b = b; out_ready = 1'b0;
    @(negedge clk);
    in_insn = mk_fix(4'h4, 4'd1, 4'd2, 5'd0, 1'b1, 4'd3); in_op_b = 32'hFFFF_8000;
    model(in_insn, 1'b0, a, in_op_b, er2, ed, eu, ep, ec);
    chk("R10 stall ready low", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 stall hold valid", 32'(out_valid), 32'd1);
    chk("R10 stall hold result", out_result, er);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second beat", out_result, er2);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 32'd0);

    for (int k = 0; k < 400; k++) begin
      logic cmp;
      cmp = $urandom_range(0, 1) == 1;
      if (cmp)
        w = mk_cmp($urandom_range(0, 7) == 0, 4'($urandom), 5'($urandom), 4'($urandom),
                   1'($urandom), $urandom_range(0, 7) == 0, 4'($urandom));
      else
        w = mk_fix(4'($urandom), 4'($urandom), 4'($urandom), 5'($urandom),
                   1'($urandom), 4'($urandom));
      if ($urandom_range(0, 7) == 0) w = w ^ (32'd1 << $urandom_range(0, 31));
      send(w, cmp, $urandom, $urandom, w[6] ? "rand R7" : "rand R6");
    end

    // R9 reset clears a pending beat
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset clears", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule